// File: doc/BRIEF.md
# Per-CPU Routed Level Interrupt Aggregator

This block collects a vector of level-sensitive peripheral interrupt lines and produces one interrupt request per CPU. Every CPU owns a private bank of 32-bit enable words, so software decides for each CPU which sources may reach it. A source can go to one CPU, to several, or to none. The lines are captured by one register stage. Each CPU output is the OR of that CPU's enabled, captured lines. The output holds no state of its own, so it falls as soon as the source goes low or is masked.

Software reaches the banks through a plain word-addressed read/write port. A write replaces a whole enable word. No set or clear aliases exist. No priority encoder exists either, so an interrupt handler finds the active sources by reading every status word of its CPU. A status word is the captured line vector masked by that CPU's enable word. Status words are read-only.

Top module: `lvl_irq_router`

## Requirements
- R1: While reset is asserted and after it is released, every enable bit of every CPU is zero, every `cpu_irq` bit is zero, and every enable word reads zero until it is written.
- R2: The input lines pass through exactly one register stage. A change on `irq_in` shows on `cpu_irq` after the next rising clock edge and not before. A falling line deasserts its outputs after that edge, because the outputs hold no latched state.
- R3: `cpu_irq[c]` is high exactly when at least one captured input line is high and its enable bit is set in CPU c's bank.
- R4: A write to CPU c's enable words changes neither the enable state nor the output of any other CPU.
- R5: A bus word address is `{cpu, off}`, where `off` is the low 3 bits (8 words, or 0x20 bytes, per CPU window). Let W be NUM_LINES/32. For j < W, offset j holds the enable word for lines 32(W-1-j) to 32(W-1-j)+31, so the highest group comes first. Offset W+j holds the status word for the same group.
- R6: A write to an enable offset replaces all 32 bits of that word, and a read of that offset returns the value last written.
- R7: A status word reads as the captured lines ANDed with the matching enable word of that CPU. Writes to a status offset are ignored.
- R8: Offsets at or above 2W, and CPU indices at or above NUM_CPUS, read zero. Writes to them are ignored.
- R9: NUM_LINES takes only the values 32, 64 or 128. Any other value stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_LINES | Level-sensitive peripheral interrupt lines |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | CPU_W+3 | Word address: CPU index above a 3-bit word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| cpu_irq | output | NUM_CPUS | One interrupt request per CPU |

## Verification
The assertions assume that `irq_in`, `bus_sel`, `bus_we`, `bus_addr` and `bus_wdata` are stable around the rising edge. They also assume that a write strobe lasts a single cycle. The bench keeps to this by changing every input one time unit after a rising edge and by dropping the strobe right after the write edge. Random enable writes are spread over the whole address space, unmapped CPUs and offsets included. The input lines are random and sparse, so both masked and unmasked pending states occur.

// File: rtl/lvl_irq_router.sv
module lvl_irq_router #(
  parameter int NUM_LINES = 32,
  parameter int NUM_CPUS  = 2,
  localparam int NUM_W    = NUM_LINES / 32,
  localparam int CPU_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  localparam int ADDR_W   = CPU_W + 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 bus_sel,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [NUM_CPUS-1:0]  cpu_irq
);

  // R9
  if (NUM_LINES != 32 && NUM_LINES != 64 && NUM_LINES != 128) begin : g_bad_lines
    $error("lvl_irq_router: NUM_LINES must be 32, 64 or 128");
  end

  localparam logic [2:0]     EN_END   = 3'(NUM_W);
  localparam logic [2:0]     ST_END   = 3'(2 * NUM_W);
  localparam bit             HAS_GAP  = (NUM_W < 4);
  localparam logic [CPU_W:0] CPU_LIM  = (CPU_W + 1)'(NUM_CPUS);

  logic [CPU_W-1:0] cpu_idx;
  logic [2:0]       off;
  logic             cpu_ok, off_gap, wr_en;

  assign cpu_idx = bus_addr[ADDR_W-1:3];
  assign off     = bus_addr[2:0];
  assign cpu_ok  = {1'b0, cpu_idx} < CPU_LIM;
  assign off_gap = HAS_GAP && (off >= ST_END);
  assign wr_en   = bus_sel && bus_we;

  logic [NUM_LINES-1:0]                irq_q;
  logic [NUM_CPUS-1:0][NUM_LINES-1:0] en;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= '0;
    end else if (wr_en) begin
      for (int c = 0; c < NUM_CPUS; c++)
        for (int j = 0; j < NUM_W; j++)
          if (cpu_idx == CPU_W'(c) && off == 3'(NUM_W - 1 - j))
            en[c][32*j +: 32] <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < NUM_CPUS; c++)
      for (int j = 0; j < NUM_W; j++)
        if (cpu_idx == CPU_W'(c)) begin
          if (off == 3'(NUM_W - 1 - j))
            bus_rdata = en[c][32*j +: 32];
          else if (off == 3'(2 * NUM_W - 1 - j))
            bus_rdata = en[c][32*j +: 32] & irq_q[32*j +: 32];
        end
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    assign cpu_irq[c] = |(en[c] & irq_q);

    // R3
    masked_cpu_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en[c] == '0) |-> !cpu_irq[c]);

    // R2
    idle_lines_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(irq_in) == '0) |-> !cpu_irq[c]);

    for (genvar j = 0; j < NUM_W; j++) begin : g_word
      // R6
      en_replace_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cpu_idx == CPU_W'(c) && off == 3'(NUM_W - 1 - j))
        |=> (en[c][32*j +: 32] == $past(bus_wdata)));
    end
  end

  // R7
  status_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && off >= EN_END) |=> $stable(en));

  // R8
  unmapped_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (off_gap || !cpu_ok) |-> (bus_rdata == '0));

  // R8
  foreign_cpu_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !cpu_ok) |=> $stable(en));

endmodule

// File: tb/tb_lvl_irq_router.sv
module tb_lvl_irq_router;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 64;
  localparam int NC = 3;
  localparam int NW = NL / 32;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] irq_in = '0;
  logic          bus_sel = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NC-1:0] cpu_irq;

  lvl_irq_router #(.NUM_LINES(NL), .NUM_CPUS(NC)) dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_irq(cpu_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [31:0]   en_m [NC][NW];
  logic [NL-1:0] irq_q_m = '0;

  function automatic logic [31:0] exp_rd(logic [AW-1:0] a);
    int cpu = int'(a[4:3]);
    int off = int'(a[2:0]);
    if (cpu >= NC) return '0;
    if (off < NW) return en_m[cpu][NW-1-off];
    if (off < 2*NW) return en_m[cpu][2*NW-1-off] & irq_q_m[32*(2*NW-1-off) +: 32];
    return '0;
  endfunction

  function automatic logic exp_irq(int c);
    for (int g = 0; g < NW; g++)
      if (|(en_m[c][g] & irq_q_m[32*g +: 32])) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    irq_q_m = irq_in;
    #1;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    int cpu = int'(a[4:3]);
    int off = int'(a[2:0]);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    if (cpu < NC && off < NW) en_m[cpu][NW-1-off] = d;
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd_check(string req, logic [AW-1:0] a, logic [31:0] exp);
    bus_addr = a; bus_sel = 1'b1;
    #1;
    check(req, bus_rdata, exp);
    bus_sel = 1'b0;
  endtask

  task automatic check_all();
    for (int c = 0; c < NC; c++) check("R3", 32'(cpu_irq[c]), 32'(exp_irq(c)));
    for (int a = 0; a < 32; a++) begin
      logic [AW-1:0] aa = AW'(a);
      string tag = (int'(aa[4:3]) >= NC || int'(aa[2:0]) >= 2*NW) ? "R8" :
                   (int'(aa[2:0]) < NW) ? "R6" : "R7";
      rd_check(tag, aa, exp_rd(aa));
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_up();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int c = 0; c < NC; c++) for (int g = 0; g < NW; g++) en_m[c][g] = '0;
    irq_in = '1;
    repeat (3) tick();
    check("R1", 32'(cpu_irq), 32'h0);
    rst_n = 1'b1;
    irq_q_m = '0;
    irq_in = '0;
    tick();
    check("R1", 32'(cpu_irq), 32'h0);
    for (int c = 0; c < NC; c++)
      for (int j = 0; j < NW; j++) rd_check("R1", AW'(c*8 + j), 32'h0);

    // R5: offset 0 is the upper line group
    wr(AW'(0), 32'h1);
    irq_in = '0; irq_in[32] = 1'b1;
    tick();
    check("R5", 32'(cpu_irq), 32'h1);
    rd_check("R5", AW'(2), 32'h1);
    rd_check("R5", AW'(3), 32'h0);
    irq_in = '0; irq_in[0] = 1'b1;
    tick();
    check("R5", 32'(cpu_irq), 32'h0);

    // R4: cpu 1 lower word only
    wr(AW'(9), 32'h1);
    tick();
    check("R4", 32'(cpu_irq), 32'h2);
    rd_check("R4", AW'(1), 32'h0);

    // R2: one register stage, no latching
    irq_in = '0;
    #1;
    check("R2", 32'(cpu_irq), 32'h2);
    tick();
    check("R2", 32'(cpu_irq), 32'h0);
    irq_in[0] = 1'b1;
    #1;
    check("R2", 32'(cpu_irq), 32'h0);
    tick();
    check("R2", 32'(cpu_irq), 32'h2);

    // R7: status write ignored
    wr(AW'(11), 32'hffff_ffff);
    rd_check("R7", AW'(9), 32'h1);
    rd_check("R7", AW'(11), 32'h1);

    // R8: unmapped cpu and offset writes ignored
    wr(AW'(25), 32'hffff_ffff);
    wr(AW'(5), 32'hffff_ffff);
    check_all();

    // R6: write replaces the whole word
    wr(AW'(9), 32'h2);
    rd_check("R6", AW'(9), 32'h2);
    check("R6", 32'(cpu_irq), 32'h0);

    for (int i = 0; i < 400; i++) begin
      int op = int'($urandom_range(0, 3));
      if (op == 0) begin
        irq_in = {$urandom(), $urandom()} & {$urandom(), $urandom()} & {$urandom(), $urandom()};
        tick();
      end else if (op == 1) begin
        irq_in = '0;
        tick();
      end else begin
        wr(AW'($urandom_range(0, 31)), $urandom() & $urandom());
      end
      check_all();
    end
    finish_up();
  end
endmodule